// File: doc/BRIEF.md
# Burst Bus Initiator

This block is the requesting side of a synchronous burst bus whose address and data share one set of wires. A local client hands it a request holding a direction, a starting address and a word count. The initiator then raises its span signal and spends one cycle on the address phase, driving the command code and the starting address. After that it moves the burst one word at a time. A word crosses the bus only in a cycle where the initiator's own ready line and the target's ready line are both high, so either side can stall the transfer on its own.

The span signal falls as soon as exactly one word is left, which tells the target that the next completed transfer ends the burst. After that final word the initiator drops its ready line and the bus goes idle for at least one cycle before another address phase can begin. On the client side, write words come in through a valid/ready stream and pass through a one-word holding register. Read words are caught in a one-word register and go out on a second valid/ready stream. The initiator ready line reflects whether that local buffering can take part in a transfer.

Top module: `burst_init`

## Requirements
- R1: After reset, span, initiator ready, data-drive enable and the command are all low, the command is 2'b00, req_ready is high and no read word is offered.
- R2: A request accepted in an idle cycle (req_valid and req_ready both high) leads, in the next cycle, to the address phase. In that phase span is high, the data-drive enable is high, the bus carries the request address, initiator ready is low and the command is not 2'b00.
- R3: A burst whose length field is n moves exactly n+1 words. A word moves only in a cycle where initiator ready and target ready are both high, and initiator ready is never high outside a burst's data phase.
- R4: On each transfer in the data phase, span is high when more than one word remains, counting the current one. Span is low when the current word is the last. A one-word burst therefore has span low from its first data cycle.
- R5: In the cycle after the final transfer, span, initiator ready and the command are low, and req_ready is high.
- R6: On a write, the words appear on the bus in the order the client supplied them, with the data-drive enable high. Initiator ready is high only when a supplied word is waiting to go out.
- R7: On a read, the words taken from the bus reach the client in bus order. A word that is offered stays unchanged until the client takes it. Initiator ready is low while the one-word read register is full and the client is not ready.
- R8: While the target holds its ready low during a write data phase, the word on the bus and initiator ready stay unchanged.
- R9: The command is 2'b10 for a read and 2'b11 for a write, and it is 2'b00 in every cycle outside the address phase.
- R10: A request presented while a burst is in progress is not accepted: req_ready is low whenever span or initiator ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Client presents a burst request |
| req_ready | output | 1 | Initiator idle and able to accept a request |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_addr | input | DW | Starting address |
| req_len | input | LW | Word count minus one |
| usr_wr_valid | input | 1 | Client write word valid |
| usr_wr_ready | output | 1 | Write word accepted this cycle |
| usr_wr_data | input | DW | Client write word |
| usr_rd_valid | output | 1 | Read word offered to the client |
| usr_rd_ready | input | 1 | Client takes the read word |
| usr_rd_data | output | DW | Read word |
| bus_span | output | 1 | Framing: high from the address phase until one word remains |
| bus_cmd | output | 2 | Command code during the address phase |
| bus_ad_out | output | DW | Address or write data driven onto the shared path |
| bus_ad_oe | output | 1 | Enable for driving bus_ad_out |
| bus_mrdy | output | 1 | Initiator ready |
| bus_srdy | input | 1 | Target ready |
| bus_ad_in | input | DW | Read data from the shared path |

## Verification
If the remaining-word counter is off by one, span falls one transfer early or late. The scoreboard sees this on the next completed transfer, and the final word either leaves one extra transfer or takes one away. A corrupted phase shows up in the very next cycle: the command appears outside the address phase, or initiator ready rises with nothing buffered. A holding register that fails to keep its word through a target wait state shows up as a changed bus word at the next completed write transfer, or as a read word out of order at the client.

// File: rtl/burst_init_pkg.sv
package burst_init_pkg;

    typedef enum logic [1:0] {
        CMD_NONE  = 2'b00,
        CMD_READ  = 2'b10,
        CMD_WRITE = 2'b11
    } bus_cmd_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'b00,
        PH_ADDR = 2'b01,
        PH_DATA = 2'b10
    } phase_e;

endpackage

// File: rtl/burst_seq.sv
module burst_seq
    import burst_init_pkg::*;
#(
    parameter int DW = 32,
    parameter int LW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [DW-1:0] req_addr,
    input  logic [LW-1:0] req_len,
    input  logic          word_ok,
    input  logic          srdy,
    output logic          req_ready,
    output logic          span,
    output logic          mrdy,
    output logic          xfer,
    output logic          in_addr,
    output logic          in_data,
    output logic          is_write,
    output logic [DW-1:0] start_addr
);
    localparam int CW = LW + 1;

    typedef struct packed {
        phase_e        ph;
        logic          wr;
        logic [DW-1:0] addr;
        logic [CW-1:0] left;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        in_addr    = (st_q.ph == PH_ADDR);
        in_data    = (st_q.ph == PH_DATA);
        is_write   = st_q.wr;
        start_addr = st_q.addr;
        req_ready  = (st_q.ph == PH_IDLE);
        mrdy       = in_data && word_ok;
        xfer       = mrdy && srdy;
        span       = in_addr || (in_data && (st_q.left > CW'(1)));

        st_d = st_q;
        unique case (st_q.ph)
            PH_IDLE: begin
                if (req_valid) begin
                    st_d.ph   = PH_ADDR;
                    st_d.wr   = req_write;
                    st_d.addr = req_addr;
                    st_d.left = CW'(req_len) + CW'(1);
                end
            end
            PH_ADDR: begin
                st_d.ph = PH_DATA;
            end
            PH_DATA: begin
                if (xfer) begin
                    st_d.left = st_q.left - CW'(1);
                    if (st_q.left == CW'(1)) begin
                        st_d.ph = PH_IDLE;
                    end
                end
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_IDLE, wr: 1'b0, addr: '0, left: '0};
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/burst_wpath.sv
module burst_wpath #(
    parameter int DW = 32,
    parameter int LW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [LW-1:0] len,
    input  logic          active,
    input  logic          xfer,
    input  logic          usr_wr_valid,
    input  logic [DW-1:0] usr_wr_data,
    output logic          usr_wr_ready,
    output logic          full,
    output logic [DW-1:0] word
);
    localparam int CW = LW + 1;

    typedef struct packed {
        logic          full;
        logic [DW-1:0] data;
        logic [CW-1:0] pend;
    } wbuf_t;

    wbuf_t wb_d, wb_q;
    logic  pull;

    always_comb begin
        full         = wb_q.full;
        word         = wb_q.data;
        usr_wr_ready = active && (wb_q.pend != '0) && (!wb_q.full || xfer);
        pull         = usr_wr_ready && usr_wr_valid;

        wb_d = wb_q;
        if (start) begin
            wb_d.pend = CW'(len) + CW'(1);
        end
        if (pull) begin
            wb_d.full = 1'b1;
            wb_d.data = usr_wr_data;
            wb_d.pend = wb_q.pend - CW'(1);
        end else if (xfer) begin
            wb_d.full = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_q <= '{full: 1'b0, data: '0, pend: '0};
        end else begin
            wb_q <= wb_d;
        end
    end

endmodule

// File: rtl/burst_rpath.sv
module burst_rpath #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic [DW-1:0] bus_word,
    input  logic          usr_rd_ready,
    output logic          usr_rd_valid,
    output logic [DW-1:0] usr_rd_data,
    output logic          room
);
    typedef struct packed {
        logic          full;
        logic [DW-1:0] data;
    } rbuf_t;

    rbuf_t rb_d, rb_q;

    always_comb begin
        usr_rd_valid = rb_q.full;
        usr_rd_data  = rb_q.data;
        room         = !rb_q.full || usr_rd_ready;

        rb_d = rb_q;
        if (take) begin
            rb_d.full = 1'b1;
            rb_d.data = bus_word;
        end else if (rb_q.full && usr_rd_ready) begin
            rb_d.full = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rb_q <= '{full: 1'b0, data: '0};
        end else begin
            rb_q <= rb_d;
        end
    end

endmodule

// File: rtl/burst_init.sv
module burst_init
    import burst_init_pkg::*;
#(
    parameter int DW = 32,
    parameter int LW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [DW-1:0] req_addr,
    input  logic [LW-1:0] req_len,
    input  logic          usr_wr_valid,
    output logic          usr_wr_ready,
    input  logic [DW-1:0] usr_wr_data,
    output logic          usr_rd_valid,
    input  logic          usr_rd_ready,
    output logic [DW-1:0] usr_rd_data,
    output logic          bus_span,
    output logic [1:0]    bus_cmd,
    output logic [DW-1:0] bus_ad_out,
    output logic          bus_ad_oe,
    output logic          bus_mrdy,
    input  logic          bus_srdy,
    input  logic [DW-1:0] bus_ad_in
);
    logic          word_ok, xfer, in_addr, in_data, is_write;
    logic [DW-1:0] start_addr;
    logic          w_full, r_room;
    logic [DW-1:0] w_word;

    burst_seq #(.DW(DW), .LW(LW)) i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_len    (req_len),
        .word_ok    (word_ok),
        .srdy       (bus_srdy),
        .req_ready  (req_ready),
        .span       (bus_span),
        .mrdy       (bus_mrdy),
        .xfer       (xfer),
        .in_addr    (in_addr),
        .in_data    (in_data),
        .is_write   (is_write),
        .start_addr (start_addr)
    );

    burst_wpath #(.DW(DW), .LW(LW)) i_wpath (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (req_valid && req_ready && req_write),
        .len          (req_len),
        .active       ((in_addr || in_data) && is_write),
        .xfer         (xfer && is_write),
        .usr_wr_valid (usr_wr_valid),
        .usr_wr_data  (usr_wr_data),
        .usr_wr_ready (usr_wr_ready),
        .full         (w_full),
        .word         (w_word)
    );

    burst_rpath #(.DW(DW)) i_rpath (
        .clk          (clk),
        .rst_n        (rst_n),
        .take         (xfer && !is_write),
        .bus_word     (bus_ad_in),
        .usr_rd_ready (usr_rd_ready),
        .usr_rd_valid (usr_rd_valid),
        .usr_rd_data  (usr_rd_data),
        .room         (r_room)
    );

    always_comb begin
        word_ok   = is_write ? w_full : r_room;
        bus_ad_oe = in_addr || (in_data && is_write);
        if (in_addr) begin
            bus_cmd    = is_write ? CMD_WRITE : CMD_READ;
            bus_ad_out = start_addr;
        end else begin
            bus_cmd    = CMD_NONE;
            bus_ad_out = (in_data && is_write) ? w_word : '0;
        end
    end

endmodule

// File: rtl/burst_init_chk.sv
module burst_init_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic          usr_rd_valid,
    input logic          usr_rd_ready,
    input logic [DW-1:0] usr_rd_data,
    input logic          bus_span,
    input logic [1:0]    bus_cmd,
    input logic [DW-1:0] bus_ad_out,
    input logic          bus_ad_oe,
    input logic          bus_mrdy,
    input logic          bus_srdy
);
    AST_ACCEPT_TO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> bus_span && bus_ad_oe && !bus_mrdy && bus_cmd != 2'b00); // R2

    AST_CMD_ONLY_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cmd != 2'b00 |-> bus_span && bus_ad_oe && !bus_mrdy); // R9

    AST_LAST_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_mrdy && bus_srdy && !bus_span |=> !bus_mrdy && !bus_span && req_ready); // R5

    AST_WAIT_HOLDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_mrdy && !bus_srdy && bus_ad_oe |=> bus_mrdy && $stable(bus_ad_out)); // R8

    AST_BUSY_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        bus_span || bus_mrdy |-> !req_ready); // R10

    AST_RD_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        usr_rd_valid && !usr_rd_ready |=> usr_rd_valid && $stable(usr_rd_data)); // R7

endmodule

bind burst_init burst_init_chk #(.DW(DW)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .usr_rd_valid (usr_rd_valid),
    .usr_rd_ready (usr_rd_ready),
    .usr_rd_data  (usr_rd_data),
    .bus_span     (bus_span),
    .bus_cmd      (bus_cmd),
    .bus_ad_out   (bus_ad_out),
    .bus_ad_oe    (bus_ad_oe),
    .bus_mrdy     (bus_mrdy),
    .bus_srdy     (bus_srdy)
);

// File: tb/test_burst_init.sv
`timescale 1ns/100ps
module test_burst_init;
    localparam int DW = 32;
    localparam int LW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_ready, req_write = 1'b0;
    logic [DW-1:0] req_addr = '0;
    logic [LW-1:0] req_len = '0;
    logic          usr_wr_valid = 1'b0, usr_wr_ready;
    logic [DW-1:0] usr_wr_data = '0;
    logic          usr_rd_valid, usr_rd_ready = 1'b0;
    logic [DW-1:0] usr_rd_data;
    logic          bus_span, bus_ad_oe, bus_mrdy, bus_srdy = 1'b0;
    logic [1:0]    bus_cmd;
    logic [DW-1:0] bus_ad_out, bus_ad_in = '0;

    always #2 clk = ~clk;

    burst_init #(.DW(DW), .LW(LW)) i_burst_init (.*);

    typedef struct {
        bit            wr;
        logic [DW-1:0] addr;
        int            words;
    } hdr_t;

    hdr_t          hdr_q[$];
    logic [DW-1:0] send_q[$];
    logic [DW-1:0] exp_wr_q[$];
    logic [DW-1:0] exp_rd_q[$];

    int checks = 0, fails = 0;
    int srdy_pct = 60, feed_pct = 70, rdy_pct = 70;
    bit done = 0;

    task automatic check(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [DW-1:0] tdata(input logic [DW-1:0] a, input int i);
        return (a + DW'(i * 4)) ^ 32'hc3c3_0000;
    endfunction

    task automatic run_burst(input bit wr, input logic [DW-1:0] a, input int n);
        bit acc;
        hdr_q.push_back('{wr: wr, addr: a, words: n});
        for (int i = 0; i < n; i++) begin
            if (wr) begin
                send_q.push_back({a[15:0], 16'(i)} ^ 32'h5a5a_0000);
                exp_wr_q.push_back({a[15:0], 16'(i)} ^ 32'h5a5a_0000);
            end else begin
                exp_rd_q.push_back(tdata(a, i));
            end
        end
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_len   = LW'(n - 1);
        do begin
            #1 acc = req_ready;
            @(negedge clk);
        end while (!acc);
        req_valid = 1'b0;
        req_addr  = 32'hdead_beef;
    endtask

    // Target model, client streams and scoreboard monitor in one process
    initial begin : monitor
        bit            in_burst = 0, cur_wr = 0, expect_idle = 0, wr_acc = 0, held_v = 0;
        int            left = 0, idx = 0, handed = 0, wx = 0, rx = 0, rdel = 0;
        logic [DW-1:0] base = '0, held = '0, e;
        hdr_t          h;
        forever begin
            @(negedge clk);
            if (wr_acc) begin
                void'(send_q.pop_front());
                handed++;
            end
            bus_srdy     = ($urandom_range(99) < srdy_pct);
            usr_rd_ready = ($urandom_range(99) < rdy_pct);
            usr_wr_valid = (send_q.size() > 0) && ($urandom_range(99) < feed_pct);
            usr_wr_data  = (send_q.size() > 0) ? send_q[0] : '0;
            bus_ad_in    = (in_burst && !cur_wr) ? tdata(base, idx) : '0;
            #1;
            if (!rst_n) continue;
            wr_acc = usr_wr_valid && usr_wr_ready;
            if (expect_idle) begin
                check(!bus_mrdy && !bus_span && bus_cmd == 2'b00 && req_ready, "R5 idle after last word",
                      {bus_mrdy, bus_span, bus_cmd, req_ready}, {DW{1'b0}} | 5'b00001);
                expect_idle = 0;
            end
            if (bus_span || bus_mrdy)
                check(!req_ready, "R10 request blocked while busy", req_ready, 0);
            if (bus_cmd != 2'b00) begin
                h = hdr_q.pop_front();
                check(bus_cmd == (h.wr ? 2'b11 : 2'b10), "R9 command code", bus_cmd, h.wr ? 2'b11 : 2'b10);
                check(bus_ad_out == h.addr && bus_ad_oe && bus_span && !bus_mrdy, "R2 address phase",
                      bus_ad_out, h.addr);
                in_burst = 1; cur_wr = h.wr; left = h.words; base = h.addr; idx = 0; held_v = 0;
            end else if (!in_burst) begin
                check(!bus_mrdy, "R3 no initiator ready outside burst", bus_mrdy, 0);
            end
            if (in_burst && bus_mrdy) begin
                if (cur_wr) check(handed > wx, "R6 ready only with buffered word", handed, wx + 1);
                else check(!((rx > rdel) && !usr_rd_ready), "R7 ready blocked by full read register", bus_mrdy, 0);
            end
            if (in_burst && bus_mrdy && bus_srdy) begin
                check(bus_span == (left > 1), "R4 span versus words left", bus_span, left > 1);
                if (cur_wr) begin
                    e = exp_wr_q.pop_front();
                    check(bus_ad_out == e && bus_ad_oe, "R6 write word order", bus_ad_out, e);
                    if (held_v) check(bus_ad_out == held, "R8 word held through target wait", bus_ad_out, held);
                    wx++;
                end else begin
                    rx++;
                end
                held_v = 0;
                left--; idx++;
                if (left == 0) begin
                    in_burst = 0;
                    expect_idle = 1;
                end
            end else if (in_burst && bus_mrdy && !bus_srdy && cur_wr) begin
                if (!held_v) held = bus_ad_out;
                held_v = 1;
            end
            if (usr_rd_valid && usr_rd_ready) begin
                e = (exp_rd_q.size() > 0) ? exp_rd_q.pop_front() : 'x;
                check(usr_rd_data === e, "R7 read word order", usr_rd_data, e);
                rdel++;
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check(!bus_span && !bus_mrdy && !bus_ad_oe && bus_cmd == 2'b00 && req_ready && !usr_rd_valid,
              "R1 reset state", {bus_span, bus_mrdy, bus_ad_oe, bus_cmd, req_ready, usr_rd_valid}, 7'b0000010);
        // single-word bursts: span low from the first data cycle (R4)
        run_burst(1, 32'h0000_1000, 1);
        run_burst(0, 32'h0000_2000, 1);
        // longest bursts, R3 word count
        run_burst(1, 32'h0000_3000, 16);
        run_burst(0, 32'h0000_4000, 16);
        // full rate on both sides
        srdy_pct = 100; feed_pct = 100; rdy_pct = 100;
        run_burst(1, 32'h0000_5000, 8);
        run_burst(0, 32'h0000_6000, 8);
        // heavy target waits (R8) and slow client (R6, R7)
        srdy_pct = 25; feed_pct = 30; rdy_pct = 20;
        run_burst(1, 32'h0000_7000, 5);
        run_burst(0, 32'h0000_8000, 5);
        srdy_pct = 60; feed_pct = 70; rdy_pct = 60;
        for (int k = 0; k < 40; k++)
            run_burst(bit'($urandom_range(1)), 32'h0001_0000 + DW'(k * 256), $urandom_range(16, 1));
        while (hdr_q.size() > 0 || exp_wr_q.size() > 0 || exp_rd_q.size() > 0 || bus_span || bus_mrdy)
            @(negedge clk);
        repeat (4) @(negedge clk);
        check(hdr_q.size() == 0 && exp_wr_q.size() == 0 && exp_rd_q.size() == 0,
              "R3 all bursts completed with exact counts", exp_wr_q.size() + exp_rd_q.size(), 0);
        finish_run();
    end

endmodule